// File: doc/BRIEF.md
# Supply Reset Sequencer

This block produces the reset for a processor subsystem. It watches two triggers: a "supply good" flag from an external threshold comparator, and an active-low request line that is usually wired to a pushbutton. While either trigger is active, reset is held. Once every trigger has cleared, reset stays asserted for a fixed hold time and is then released.

The hold time is set in clock cycles by a parameter. A single down-counter serves both triggers. Any trigger that appears while a pulse is running reloads the counter and extends the pulse. Because of this, a bouncing button yields one clean pulse and no separate debouncer is needed. Both trigger inputs are asynchronous to the clock and are synchronized inside the block.

Reset is driven on two pins that are always complementary, one active-low and one active-high. A saturating counter reports how many reset pulses have completed.

Top module: `supply_reset_seq`

## Requirements
- R1: While `supplyOk` is low, `rstN` is 0. From an idle state, a low on `supplyOk` or `manualN` drives `rstN` to 0 no later than the third rising clock edge after the input changes.
- R2: After `supplyOk` rises, with no other trigger present, `rstN` stays 0 through the (HOLD_CYCLES+1)-th rising edge and becomes 1 after the (HOLD_CYCLES+2)-th rising edge. This latency is two synchronizer stages plus HOLD_CYCLES cycles of hold.
- R3: A low on `supplyOk` that occurs during an active pulse restarts the hold. Release happens HOLD_CYCLES+2 edges after the last rise, never earlier.
- R4: Driving `manualN` low asserts reset. Release follows HOLD_CYCLES+2 edges after `manualN` returns high.
- R5: Highs on `manualN` that last fewer than HOLD_CYCLES cycles, between lows, do not release reset. The whole burst produces exactly one pulse.
- R6: `rstHi` is always the inverse of `rstN`.
- R7: While `arstN` is low, `rstN`=0, `rstHi`=1 and `pulseCount`=0.
- R8: `pulseCount` increases by one on the edge where each pulse is released, including the power-on pulse. It holds at 2^PULSE_CNT_W-1 once it reaches that value.
- R9: While any trigger is active after synchronization, the hold counter is kept at HOLD_CYCLES. With no trigger, it counts down by one per cycle until it reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| arstN | input | 1 | Asynchronous initialization, active low |
| supplyOk | input | 1 | Supply-good flag from the comparator, asynchronous |
| manualN | input | 1 | Manual reset request, active low, asynchronous |
| rstN | output | 1 | Reset output, active low |
| rstHi | output | 1 | Reset output, active high |
| pulseCount | output | PULSE_CNT_W | Completed reset pulses, saturating |

## Verification
The hardest case to reach is a trigger that arrives while the hold counter is partway down. Only reload timing tells an extended pulse from two separate pulses in that case. The bench reaches it from the ports by sweeping the high gap of a button burst across every value from 1 to HOLD_CYCLES-1, with a small HOLD_CYCLES. It also places a supply dip halfway through a running pulse. In each case it measures the exact release edge and the pulse count.

// File: rtl/srs_pkg.sv
package srs_pkg;
  // Strobes from control to the hold/pulse datapath
  typedef struct packed {
    logic loadHold;   // reload hold counter to full interval
    logic stepHold;   // count hold counter down by one
    logic bumpCount;  // a pulse ends this cycle
  } holdCtrl_t;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             arstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge arstN) begin
      if (!arstN) chain <= {STAGES{INIT[b]}};
      else        chain <= {chain[STAGES-2:0], asyncIn[b]};
    end
    assign syncOut[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
(
  input  logic      clk,
  input  logic      arstN,
  input  logic      trigger,
  input  logic      holdLast,
  input  logic      holdIdle,
  output holdCtrl_t ctrl,
  output logic      resetActive
);
  logic activeNext;

  always_comb begin
    ctrl.loadHold  = trigger;
    ctrl.stepHold  = !trigger && !holdIdle;
    ctrl.bumpCount = ctrl.stepHold && holdLast;
    activeNext     = ctrl.loadHold || (ctrl.stepHold && !holdLast);
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) resetActive <= 1'b1;
    else        resetActive <= activeNext;
  end
endmodule

// File: rtl/srs_datapath.sv
module srs_datapath
  import srs_pkg::*;
#(
  parameter int HOLD_CYCLES = 8,
  parameter int CNT_W       = 8,
  localparam int HW = $clog2(HOLD_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             arstN,
  input  holdCtrl_t        ctrl,
  output logic [HW-1:0]    holdCnt,
  output logic             holdLast,
  output logic             holdIdle,
  output logic [CNT_W-1:0] pulseCount
);
  localparam logic [HW-1:0]    HOLD_V = HW'(HOLD_CYCLES);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)             holdCnt <= HOLD_V;
    else if (ctrl.loadHold) holdCnt <= HOLD_V;
    else if (ctrl.stepHold) holdCnt <= holdCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) pulseCount <= '0;
    else if (ctrl.bumpCount && pulseCount != CNT_MAX)
      pulseCount <= pulseCount + 1'b1;
  end

  assign holdLast = (holdCnt == HW'(1));
  assign holdIdle = (holdCnt == '0);
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
  import srs_pkg::*;
#(
  parameter int HOLD_CYCLES = 10_000_000,
  parameter int PULSE_CNT_W = 8,
  localparam int HW = $clog2(HOLD_CYCLES + 1)
) (
  input  logic                   clk,
  input  logic                   arstN,
  input  logic                   supplyOk,
  input  logic                   manualN,
  output logic                   rstN,
  output logic                   rstHi,
  output logic [PULSE_CNT_W-1:0] pulseCount
);
  logic [1:0]  syncIn;
  logic        trigger;
  logic        holdLast;
  logic        holdIdle;
  logic        resetActive;
  logic [HW-1:0] holdCnt;
  holdCtrl_t   ctrl;

  // bit1: supply good, bit0: manual request (low = request); both init to "trigger"
  srs_sync #(.WIDTH(2), .STAGES(2), .INIT(2'b00)) sync_i (
    .clk(clk), .arstN(arstN), .asyncIn({supplyOk, manualN}), .syncOut(syncIn)
  );

  assign trigger = !syncIn[1] || !syncIn[0];

  srs_ctrl ctrl_i (
    .clk(clk), .arstN(arstN), .trigger(trigger), .holdLast(holdLast),
    .holdIdle(holdIdle), .ctrl(ctrl), .resetActive(resetActive)
  );

  srs_datapath #(.HOLD_CYCLES(HOLD_CYCLES), .CNT_W(PULSE_CNT_W)) dp_i (
    .clk(clk), .arstN(arstN), .ctrl(ctrl), .holdCnt(holdCnt),
    .holdLast(holdLast), .holdIdle(holdIdle), .pulseCount(pulseCount)
  );

  assign rstN  = !resetActive;
  assign rstHi = resetActive;
endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
  parameter int HOLD_CYCLES = 8,
  parameter int CNT_W       = 8,
  localparam int HW = $clog2(HOLD_CYCLES + 1)
) (
  input logic             clk,
  input logic             arstN,
  input logic             trigger,
  input logic [HW-1:0]    holdCnt,
  input logic             rstN,
  input logic             rstHi,
  input logic [CNT_W-1:0] pulseCount
);
  localparam logic [HW-1:0]    HOLD_V = HW'(HOLD_CYCLES);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r6_complement: assert property (@(posedge clk) disable iff (!arstN)
    rstHi != rstN);

  a_r1_trigger_holds: assert property (@(posedge clk) disable iff (!arstN)
    trigger |=> !rstN);

  a_r9_reload: assert property (@(posedge clk) disable iff (!arstN)
    trigger |=> holdCnt == HOLD_V);

  a_r9_countdown: assert property (@(posedge clk) disable iff (!arstN)
    (!trigger && holdCnt != '0) |=> holdCnt == $past(holdCnt) - 1'b1);

  a_r8_step: assert property (@(posedge clk) disable iff (!arstN)
    ($fell(rstHi) && $past(pulseCount) != CNT_MAX) |-> pulseCount == $past(pulseCount) + 1'b1);

  a_r8_saturate: assert property (@(posedge clk) disable iff (!arstN)
    ($past(pulseCount) == CNT_MAX) |-> pulseCount == CNT_MAX);

  a_r8_quiet: assert property (@(posedge clk) disable iff (!arstN)
    !$fell(rstHi) |-> $stable(pulseCount));
endmodule

bind supply_reset_seq srs_checker #(.HOLD_CYCLES(HOLD_CYCLES), .CNT_W(PULSE_CNT_W)) chk_i (
  .clk(clk), .arstN(arstN), .trigger(trigger), .holdCnt(holdCnt),
  .rstN(rstN), .rstHi(rstHi), .pulseCount(pulseCount)
);

// File: tb/supply_reset_seq_tb_top.sv
module supply_reset_seq_tb_top;
  localparam int H  = 8;
  localparam int CW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic arstN, supplyOk, manualN;
  logic rstN, rstHi;
  logic [CW-1:0] pulseCount;
  int checks = 0;
  int errors = 0;
  int expPulses = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  supply_reset_seq #(.HOLD_CYCLES(H), .PULSE_CNT_W(CW)) dut_i (
    .clk(clk), .arstN(arstN), .supplyOk(supplyOk), .manualN(manualN),
    .rstN(rstN), .rstHi(rstHi), .pulseCount(pulseCount)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic stepN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at the negedge where the last trigger input has just gone high
  task automatic expectRelease(input string tag);
    stepN(H + 1);
    chk(rstN == 1'b0, {tag, " still held"}, rstN, 0);
    stepN(1);
    chk(rstN == 1'b1, {tag, " released"}, rstN, 1);
    expPulses++;
    chk(int'(pulseCount) == ((expPulses > CMAX) ? CMAX : expPulses),
        "R8 pulse count", pulseCount, (expPulses > CMAX) ? CMAX : expPulses);
  endtask

  // Hold one trigger low for len cycles; sel 1 = supply, 0 = manual
  task automatic lowPulse(input bit sel, input int len, input string tag);
    if (sel) supplyOk = 1'b0; else manualN = 1'b0;
    for (int i = 1; i <= len; i++) begin
      stepN(1);
      if (i >= 3) chk(rstN == 1'b0, {tag, " asserted while low"}, rstN, 0);
    end
    if (sel) supplyOk = 1'b1; else manualN = 1'b1;
  endtask

  // R6 monitor
  always @(negedge clk) if (arstN === 1'b1 && !done)
    chk(rstHi == ~rstN, "R6 complement", rstHi, ~rstN);

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R0 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    arstN = 1'b0; supplyOk = 1'b0; manualN = 1'b1;
    stepN(3);
    chk(rstN == 1'b0, "R7 rstN in init", rstN, 0);
    chk(rstHi == 1'b1, "R7 rstHi in init", rstHi, 1);
    chk(pulseCount == '0, "R7 count in init", pulseCount, 0);
    arstN = 1'b1; supplyOk = 1'b1;
    expectRelease("R2 power-on");

    // R1 / R2: supply dips of several lengths, plus a long one
    for (int len = 1; len <= 5; len++) begin
      lowPulse(1'b1, len, "R1 supply");
      expectRelease("R2 supply rise");
    end
    lowPulse(1'b1, 20, "R1 long supply low");
    expectRelease("R2 after long low");

    // R4: manual requests of several lengths
    for (int len = 1; len <= 5; len++) begin
      lowPulse(1'b0, len, "R4 manual");
      expectRelease("R4 manual release");
    end

    // R3: dip in the middle of a running pulse
    lowPulse(1'b1, 3, "R3 first dip");
    stepN(H / 2);
    chk(rstN == 1'b0, "R3 mid pulse", rstN, 0);
    lowPulse(1'b1, 2, "R3 second dip");
    expectRelease("R3 extended");

    // R5: bounce with every gap shorter than the hold
    for (int g = 1; g <= H - 1; g++) begin
      lowPulse(1'b0, 2, "R5 bounce a");
      stepN(g);
      chk(rstN == 1'b0, "R5 gap held", rstN, 0);
      lowPulse(1'b0, 2, "R5 bounce b");
      expectRelease("R5 single pulse");
    end

    // R5 contrast: gap longer than hold gives two pulses
    lowPulse(1'b0, 2, "R5 long gap a");
    expectRelease("R5 first of two");
    lowPulse(1'b0, 2, "R5 long gap b");
    expectRelease("R5 second of two");

    // R8: count has saturated by now
    chk(int'(pulseCount) == CMAX, "R8 saturated", pulseCount, CMAX);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule